// File: doc/BRIEF.md
# Serial ADC Readout Host Controller

This block sits on the host side of a three-wire serial analog-to-digital converter that runs with its select line doubling as the convert-start line and with the busy indicator enabled. When a start request arrives while the block is idle, it drives the convert line high, which starts a conversion. It then returns the line low well inside the converter's minimum conversion time and waits for the converter to pull its data line low. That low level is the busy bit, and it marks the end of the conversion.

Once the busy bit is seen, the block toggles a serial clock that idles high. The converter shifts out one data bit on each clock falling edge, MSB first. The block captures each bit on the rising edge that follows. After the sixteenth bit it issues one more falling edge, and that edge makes the converter release its data line. The block then offers the captured word on a valid/ready result port.

A busy-wait output stays high while the block waits for the busy bit, so it can serve as an interrupt source. A timeout pulse reports a conversion that never signals completion.

The result port follows valid/ready rules. When a word is offered, the valid output stays high and the data stays frozen until ready is sampled high. Valid drops in the cycle after that handshake. The consumer can hold ready low for as long as it likes. During that time the controller does not start another conversion.

Top module: `adc_rd_host`

## Requirements
- R1: After reset, the convert line and result valid are low, the serial clock is high, and busy-wait and timeout are low.
- R2: A start request sampled high while idle drives the convert line high from the next cycle, for exactly HOLD_CYC cycles. HOLD_CYC must be shorter than the converter's minimum conversion time.
- R3: Busy-wait is high from the cycle in which the convert line falls. It stays high until the cycle after the data line is sampled low.
- R4: In the readout phase, the serial clock first falls SCLK_DIV cycles after busy-wait drops. It then stays low for SCLK_DIV cycles and high for SCLK_DIV cycles in turn, for exactly 17 falling edges. It ends high, and it stays high outside the readout phase.
- R5: The data line is sampled on each of the first 16 serial clock rising edges. The first sample is the result's bit 15 and the last is bit 0, so the result is the word launched on falling edges 1 to 16.
- R6: Result valid rises in the cycle of the 17th rising edge. While ready is low, valid stays high and the data stays stable. Valid is low in the cycle after valid and ready are both sampled high. The convert line stays low from its fall until that handshake.
- R7: If the data line is still high after TMO_CYC cycles of busy-wait, timeout pulses for exactly one cycle and busy-wait drops in that same cycle. No serial clock edge and no result follow, and the block returns to idle. A data line sampled low in the last allowed cycle still counts as completion.
- R8: A start request is ignored in every state other than idle. Each accepted request produces exactly one rising edge on the convert line.
- R9: A start request in the cycle right after a result handshake is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Conversion request, sampled while idle |
| cnv_o | output | 1 | Convert-start / select line to the converter |
| sclk_o | output | 1 | Serial clock to the converter, idles high |
| sdo_i | input | 1 | Converter data line (busy bit, then data MSB first) |
| busy_wait_o | output | 1 | High while waiting for the busy bit |
| timeout_o | output | 1 | One-cycle pulse when completion never appears |
| res_valid_o | output | 1 | Result word available |
| res_ready_i | input | 1 | Consumer accepts the result |
| res_data_o | output | 16 | Captured conversion result |

## Verification
Each output's timing follows a fixed cycle count measured from a stimulus:
- The convert line rises one cycle after a start request.
- Busy-wait lasts the model converter's latency minus HOLD_CYC cycles.
- The first serial clock fall comes SCLK_DIV cycles after busy-wait drops.
- Valid arrives in the same cycle as the final rising edge.
- Timeout follows exactly TMO_CYC cycles of busy-wait.

The bench drives inputs and samples outputs on the falling system clock edge. It counts sampled cycles in each phase and compares each count with the value computed from these latencies. A behavioural converter model in the bench launches bits on serial clock falling edges and counts them. This lets the bench check the word, the number of edges and the line release without looking inside the design.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;

  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_CNV   = 3'd1,
    S_WAIT  = 3'd2,
    S_SHIFT = 3'd3,
    S_OUT   = 3'd4
  } seq_state_e;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/adc_rd_sclk_gen.sv
module adc_rd_sclk_gen #(
  parameter int SCLK_DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  output logic sclk_o,
  output logic fall_o,
  output logic rise_o
);

  localparam int CW = (SCLK_DIV > 1) ? $clog2(SCLK_DIV) : 1;

  logic sclk_q;
  logic wrap;

  generate
    if (SCLK_DIV == 1) begin : g_nodiv
      assign wrap = en_i;
    end else begin : g_div
      logic [CW-1:0] cnt_q;
      assign wrap = en_i && (cnt_q == CW'(SCLK_DIV - 1));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          cnt_q <= '0;
        end else if (!en_i || wrap) begin
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_q + CW'(1);
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b1;
    end else if (!en_i) begin
      sclk_q <= 1'b1;
    end else if (wrap) begin
      sclk_q <= ~sclk_q;
    end
  end

  assign sclk_o = sclk_q;
  assign fall_o = wrap && sclk_q;
  assign rise_o = wrap && !sclk_q;

endmodule

// File: rtl/adc_rd_capture.sv
module adc_rd_capture #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              rise_i,
  input  logic              sdo_i,
  output logic [DATA_W-1:0] word_o,
  output logic              last_o
);

  localparam int BW = $clog2(DATA_W + 2);

  logic [BW-1:0]     bit_q;
  logic [DATA_W-1:0] word_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_q  <= '0;
      word_q <= '0;
    end else if (clr_i) begin
      bit_q <= '0;
    end else if (rise_i) begin
      if (bit_q < BW'(DATA_W)) begin
        word_q <= {word_q[DATA_W-2:0], sdo_i};
      end
      bit_q <= bit_q + BW'(1);
    end
  end

  assign word_o = word_q;
  assign last_o = rise_i && (bit_q == BW'(DATA_W));

  p_bitcnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    bit_q <= BW'(DATA_W + 1));

endmodule

// File: rtl/adc_rd_seq.sv
module adc_rd_seq
  import adc_rd_pkg::*;
#(
  parameter int HOLD_CYC = 6,
  parameter int TMO_CYC  = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic sdo_i,
  input  logic last_rise_i,
  input  logic sclk_i,
  input  logic res_ready_i,
  output logic cnv_o,
  output logic busy_wait_o,
  output logic shift_en_o,
  output logic res_valid_o,
  output logic timeout_o
);

  localparam int MAXC = max2(max2(HOLD_CYC, TMO_CYC), 2);
  localparam int TW   = $clog2(MAXC + 1);

  seq_state_e    state_q, state_d;
  logic [TW-1:0] cnt_q, cnt_d;
  logic          cnv_q, wait_q, valid_q, tmo_q;
  logic          tmo_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    tmo_d   = 1'b0;
    unique case (state_q)
      S_IDLE: begin
        cnt_d = '0;
        if (start_i) state_d = S_CNV;
      end
      S_CNV: begin
        if (cnt_q == TW'(HOLD_CYC - 1)) begin
          state_d = S_WAIT;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + TW'(1);
        end
      end
      S_WAIT: begin
        if (!sdo_i) begin
          state_d = S_SHIFT;
          cnt_d   = '0;
        end else if (cnt_q == TW'(TMO_CYC - 1)) begin
          state_d = S_IDLE;
          cnt_d   = '0;
          tmo_d   = 1'b1;
        end else begin
          cnt_d = cnt_q + TW'(1);
        end
      end
      S_SHIFT: begin
        if (last_rise_i) state_d = S_OUT;
      end
      S_OUT: begin
        if (res_ready_i) state_d = S_IDLE;
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      cnt_q   <= '0;
      cnv_q   <= 1'b0;
      wait_q  <= 1'b0;
      valid_q <= 1'b0;
      tmo_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      cnv_q   <= (state_d == S_CNV);
      wait_q  <= (state_d == S_WAIT);
      valid_q <= (state_d == S_OUT);
      tmo_q   <= tmo_d;
    end
  end

  assign cnv_o       = cnv_q;
  assign busy_wait_o = wait_q;
  assign res_valid_o = valid_q;
  assign timeout_o   = tmo_q;
  assign shift_en_o  = (state_q == S_SHIFT);

  p_wait_after_cnv_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cnv_q) |-> wait_q);

  p_sclk_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != S_SHIFT) |-> sclk_i);

  p_cnv_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en_o || valid_q || wait_q) |-> !cnv_q);

  p_tmo_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_q |=> !tmo_q);

  p_tmo_novalid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_q |-> (!valid_q && !wait_q && sclk_i));

endmodule

// File: rtl/adc_rd_host.sv
module adc_rd_host #(
  parameter int DATA_W   = 16,
  parameter int SCLK_DIV = 2,
  parameter int HOLD_CYC = 6,
  parameter int TMO_CYC  = 200
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  output logic              cnv_o,
  output logic              sclk_o,
  input  logic              sdo_i,
  output logic              busy_wait_o,
  output logic              timeout_o,
  output logic              res_valid_o,
  input  logic              res_ready_i,
  output logic [DATA_W-1:0] res_data_o
);

  logic shift_en;
  logic sclk_fall;
  logic sclk_rise;
  logic last_rise;

  adc_rd_seq #(
    .HOLD_CYC(HOLD_CYC),
    .TMO_CYC (TMO_CYC)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .sdo_i      (sdo_i),
    .last_rise_i(last_rise),
    .sclk_i     (sclk_o),
    .res_ready_i(res_ready_i),
    .cnv_o      (cnv_o),
    .busy_wait_o(busy_wait_o),
    .shift_en_o (shift_en),
    .res_valid_o(res_valid_o),
    .timeout_o  (timeout_o)
  );

  adc_rd_sclk_gen #(
    .SCLK_DIV(SCLK_DIV)
  ) u_sclk (
    .clk   (clk),
    .rst_n (rst_n),
    .en_i  (shift_en),
    .sclk_o(sclk_o),
    .fall_o(sclk_fall),
    .rise_o(sclk_rise)
  );

  adc_rd_capture #(
    .DATA_W(DATA_W)
  ) u_cap (
    .clk   (clk),
    .rst_n (rst_n),
    .clr_i (!shift_en),
    .rise_i(sclk_rise),
    .sdo_i (sdo_i),
    .word_o(res_data_o),
    .last_o(last_rise)
  );

  p_hold_data_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid_o && !res_ready_i) |=> (res_valid_o && $stable(res_data_o)));

  p_valid_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid_o && res_ready_i) |=> !res_valid_o);

  p_fall_in_shift_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_fall |-> (shift_en && !cnv_o));

endmodule

// File: tb/adc_rd_host_tb.sv
module adc_rd_host_tb;

  localparam int DIV  = 2;
  localparam int HOLD = 4;
  localparam int TMO  = 40;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        ready = 1'b0;
  logic        cnv, sclk, busy_wait, tmo, valid;
  logic [15:0] data;
  logic        m_sdo = 1'b1;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  adc_rd_host #(
    .DATA_W(16), .SCLK_DIV(DIV), .HOLD_CYC(HOLD), .TMO_CYC(TMO)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .cnv_o(cnv), .sclk_o(sclk),
    .sdo_i(m_sdo), .busy_wait_o(busy_wait), .timeout_o(tmo),
    .res_valid_o(valid), .res_ready_i(ready), .res_data_o(data)
  );

  // behavioural converter model
  logic [15:0] m_word = '0;
  int          m_lat  = 10;
  bit          m_mute = 1'b0;
  int          m_idx  = 0;
  int          m_rises = 0;

  always begin
    @(posedge cnv);
    m_rises++;
    m_idx = 0;
    m_sdo = 1'b1;
    repeat (m_lat) @(negedge clk);
    if (!m_mute && !cnv) m_sdo = 1'b0;
  end

  always @(negedge sclk) begin
    if (rst_n) begin
      m_idx++;
      if (m_idx <= 16) m_sdo = m_word[16 - m_idx];
      else m_sdo = 1'b1;
    end
  end

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // called at a negedge with the DUT idle
  task automatic run_conv(input logic [15:0] w, input int lat, input int rdy_wait,
                          input bit poke);
    int n, bw, d, lo, hi, r0;
    bit cnv_seen;
    m_word = w; m_lat = lat; m_mute = 1'b0;
    r0 = m_rises;
    start = 1'b1;
    @(negedge clk);
    if (!poke) start = 1'b0;
    chk("R9 convert high one cycle after start", cnv, 1);
    n = 0;
    while (cnv) begin n++; @(negedge clk); end
    chk("R2 convert high length", n, HOLD);
    chk("R3 busy-wait at convert fall", busy_wait, 1);
    bw = 0;
    while (busy_wait) begin bw++; @(negedge clk); end
    chk("R3 busy-wait length", bw, lat - HOLD);
    d = 0;
    while (sclk) begin d++; @(negedge clk); end
    chk("R4 first fall delay", d, DIV);
    lo = 0; hi = 0; cnv_seen = 1'b0;
    while (!valid) begin
      if (!sclk) lo++; else hi++;
      if (cnv) cnv_seen = 1'b1;
      @(negedge clk);
    end
    chk("R4 sclk low cycles", lo, 17 * DIV);
    chk("R4 sclk high cycles", hi, 16 * DIV);
    chk("R4 falling edge count", m_idx, 17);
    chk("R4 sclk high at valid", sclk, 1);
    for (int k = 0; k < rdy_wait; k++) begin
      chk("R6 valid held", valid, 1);
      chk("R6 data stable", data, w);
      if (cnv) cnv_seen = 1'b1;
      @(negedge clk);
    end
    chk("R6 convert low through readout", cnv_seen, 0);
    chk("R5 result word", data, w);
    ready = 1'b1;
    start = 1'b0;
    @(negedge clk);
    ready = 1'b0;
    chk("R6 valid drops after handshake", valid, 0);
    chk("R8 one convert rise per request", m_rises - r0, 1);
  endtask

  task automatic run_timeout(input int lat, input bit mute);
    int n, bw;
    m_lat = lat; m_mute = mute;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 0;
    while (cnv) begin n++; @(negedge clk); end
    chk("R2 convert high length (timeout run)", n, HOLD);
    bw = 0;
    while (busy_wait) begin
      chk("R7 no timeout during wait", tmo, 0);
      bw++; @(negedge clk);
    end
    chk("R7 wait length before timeout", bw, TMO);
    chk("R7 timeout pulse", tmo, 1);
    @(negedge clk);
    chk("R7 timeout one cycle", tmo, 0);
    chk("R7 no result", valid, 0);
    chk("R7 no sclk edge", m_idx, 0);
    chk("R7 sclk idle", sclk, 1);
    repeat (3) @(negedge clk);
    chk("R7 back to idle", cnv | valid | busy_wait, 0);
    m_mute = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] lcg;
    repeat (3) @(negedge clk);
    chk("R1 reset convert", cnv, 0);
    chk("R1 reset sclk", sclk, 1);
    chk("R1 reset valid", valid, 0);
    chk("R1 reset busy-wait", busy_wait, 0);
    chk("R1 reset timeout", tmo, 0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 16; i++)
      run_conv(16'(1) << i, HOLD + 1 + (i % 5), i % 3, 1'b0);
    run_conv(16'h0000, HOLD + 1, 0, 1'b0);
    run_conv(16'hFFFF, HOLD + 2, 4, 1'b1);
    run_conv(16'hAAAA, HOLD + 7, 1, 1'b0);
    run_conv(16'h5555, HOLD + 3, 2, 1'b1);
    lcg = 16'h1D2F;
    for (int i = 0; i < 32; i++) begin
      lcg = lcg * 16'd25173 + 16'd13849;
      run_conv(lcg, HOLD + 1 + (i * 7) % (TMO - 1), i % 4, i[0]);
    end
    run_conv(16'hC3A5, HOLD + TMO, 0, 1'b0);
    run_timeout(HOLD + 5, 1'b1);
    run_timeout(HOLD + TMO + 1, 1'b0);
    run_conv(16'h7E81, HOLD + 6, 1, 1'b0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule